// File: doc/BRIEF.md
# CPU Clock Source Switch

This block picks the CPU clock from one of two sources. One is a slow, always-running subclock. The other is a fast main oscillator clock that passes through a power-of-two divider. A small control word sets three things: whether the main oscillator runs, which source is requested, and how far the main clock is divided. A status bit, which software can only read, reports which source is actually driving the CPU.

A change of source is break-before-make. The clock that is leaving is forced low on its falling edge. The clock that is arriving is released only after it has been synchronised on its own edges. As a result, the CPU clock never shows a shortened high or low phase. The control word is clocked by the subclock, so every request is taken on a subclock boundary. Software must poll the status bit to learn that a handover has finished. Waiting for the main oscillator to stabilise is also left to software.

Top module: `cpu_clk_switch`

## Requirements
- R1: Control bit 0 (osc stop) low drives `main_osc_en_o` high. When it is high, `main_osc_en_o` goes low as soon as the main clock no longer feeds the CPU.
- R2: The control word has this layout: bit 0 is osc stop, bit 1 is source select (1 = subclock, 0 = main), bits 4:2 are the divider code. `rdata_o` returns these same five bits, with the status bit in bit 5 (1 = subclock running, 0 = main running).
- R3: Divider code n = 0..4 divides the main clock by 2^n. Codes 5, 6 and 7 divide by 16.
- R4: A write updates only the bits set in `wmask_i`. A source-select write with only bit 1 masked leaves the divider code unchanged.
- R5: Both source gates are never open at once. No phase of `cpu_clk_o` is shorter than half a period of the fastest divided main clock.
- R6: The status bit does not change in the cycle a source-select write commits. It reaches the new source, and the CPU clock runs from that source, within eight subclock periods.
- R7: After reset the control word is osc stop 0, select main, divider code 4. The status bit reads main, the oscillator is enabled, and `cpu_clk_o` runs at the main clock divided by 16.
- R8: Requesting the main clock while osc stop is set is ignored. The status bit stays at subclock and `cpu_clk_o` keeps running from the subclock.
- R9: Setting osc stop while the main clock drives the CPU forces a handover to the subclock. After that handover the oscillator enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| main_clk_i | input | 1 | Main oscillator clock |
| sub_clk_i | input | 1 | Subclock, always running |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Control write strobe, sampled on the subclock rising edge |
| wmask_i | input | 5 | Per-bit write enable for the control word |
| wdata_i | input | 5 | Control write data |
| rdata_o | output | 6 | Control word readback with the status bit in bit 5 |
| main_osc_en_o | output | 1 | Main oscillator enable |
| cpu_clk_o | output | 1 | Glitch-free CPU clock |

## Verification
The assertions assume several things about the inputs. The subclock runs without pause. The main clock toggles only while `main_osc_en_o` is high. Control writes are driven away from the subclock rising edge. The divider code and the source select are not written in the same cycle as a handover that is already running into the main clock. The stimulus keeps to all of these. The bench model of the oscillator freezes the main clock whenever the enable drops. Every write is driven on the subclock falling edge. Each write that changes the divider is made while the subclock drives the CPU. Each source change is followed by a wait long enough for the status bit to settle.

// File: rtl/clk_sw_pkg.sv
package clk_sw_pkg;
  localparam int DIV_W   = 3;
  localparam int FIELD_W = DIV_W + 2;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             sel_sub;
    logic             stop;
  } ctrl_t;
endpackage

// File: rtl/clk_sw_regs.sv
module clk_sw_regs
  import clk_sw_pkg::*;
#(
  parameter logic [DIV_W-1:0] DIV_RST     = 3'd4,
  parameter int               SYNC_STAGES = 2
) (
  input  logic               sub_clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [FIELD_W-1:0] wmask_i,
  input  logic [FIELD_W-1:0] wdata_i,
  input  logic               sub_gate_i,
  input  logic               main_gate_i,
  output ctrl_t              ctrl_o,
  output logic               status_o
);
  ctrl_t                  ctrl_q;
  logic [SYNC_STAGES-1:0] msync_q;
  logic                   status_q;

  always_ff @(posedge sub_clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '{div: DIV_RST, sel_sub: 1'b0, stop: 1'b0};
    else if (wr_i) ctrl_q <= ctrl_t'((ctrl_q & ~wmask_i) | (wdata_i & wmask_i));
  end

  // main gate lives in the divided-clock domain
  always_ff @(posedge sub_clk_i or negedge rst_ni) begin
    if (!rst_ni) msync_q <= '1;
    else         msync_q <= {msync_q[SYNC_STAGES-2:0], main_gate_i};
  end

  always_ff @(posedge sub_clk_i or negedge rst_ni) begin
    if (!rst_ni)                       status_q <= 1'b0;
    else if (sub_gate_i)               status_q <= 1'b1;
    else if (msync_q[SYNC_STAGES-1])   status_q <= 1'b0;
  end

  assign ctrl_o   = ctrl_q;
  assign status_o = status_q;

  p_hold_div_r4: assert property (@(posedge sub_clk_i) disable iff (!rst_ni)
    (wmask_i[FIELD_W-1:2] == '0) |=> $stable(ctrl_q.div));

  p_ignore_main_r8: assert property (@(posedge sub_clk_i) disable iff (!rst_ni)
    (ctrl_q.stop && $past(ctrl_q.stop) && status_q) |=> status_q);

  p_status_after_r6: assert property (@(posedge sub_clk_i) disable iff (!rst_ni)
    $fell(status_q) |-> (msync_q[SYNC_STAGES-1] && !sub_gate_i));
endmodule

// File: rtl/clk_sw_div.sv
module clk_sw_div
  import clk_sw_pkg::*;
#(
  parameter int               MAX_SHIFT = 4,
  parameter logic [DIV_W-1:0] DIV_RST   = 3'd4
) (
  input  logic             main_clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             gate_i,
  output logic             div_clk_o
);
  logic [MAX_SHIFT-1:0] cnt_q;
  logic [DIV_W-1:0]     div_lat_q;
  logic [DIV_W-1:0]     eff_div;

  always_ff @(posedge main_clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // divider only follows the control word while its output is gated off
  always_ff @(posedge main_clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_lat_q <= DIV_RST;
    else if (!gate_i) div_lat_q <= div_i;
  end

  assign eff_div = (div_lat_q > DIV_W'(MAX_SHIFT)) ? DIV_W'(MAX_SHIFT) : div_lat_q;

  always_comb begin
    div_clk_o = main_clk_i;
    for (int k = 1; k <= MAX_SHIFT; k++)
      if (eff_div == DIV_W'(k)) div_clk_o = cnt_q[k-1];
  end

  p_div_frozen_r3: assert property (@(posedge main_clk_i) disable iff (!rst_ni)
    (gate_i && $past(gate_i)) |=> $stable(div_lat_q));
endmodule

// File: rtl/clk_sw_branch.sv
module clk_sw_branch #(
  parameter int SYNC_STAGES = 2,
  parameter bit RST_ON      = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic gate_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {SYNC_STAGES{RST_ON}};
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], req_i};
  end

  // open and close only while the source is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= RST_ON;
    else         gate_q <= sync_q[SYNC_STAGES-1];
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/cpu_clk_switch.sv
module cpu_clk_switch
  import clk_sw_pkg::*;
#(
  parameter int               MAX_SHIFT   = 4,
  parameter logic [DIV_W-1:0] DIV_RST     = 3'd4,
  parameter int               SYNC_STAGES = 2
) (
  input  logic               main_clk_i,
  input  logic               sub_clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [FIELD_W-1:0] wmask_i,
  input  logic [FIELD_W-1:0] wdata_i,
  output logic [FIELD_W:0]   rdata_o,
  output logic               main_osc_en_o,
  output logic               cpu_clk_o
);
  ctrl_t ctrl;
  logic  status;
  logic  div_clk;
  logic  main_gate, sub_gate;
  logic  want_main;

  clk_sw_regs #(.DIV_RST(DIV_RST), .SYNC_STAGES(SYNC_STAGES)) u_regs (
    .sub_clk_i  (sub_clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .wmask_i    (wmask_i),
    .wdata_i    (wdata_i),
    .sub_gate_i (sub_gate),
    .main_gate_i(main_gate),
    .ctrl_o     (ctrl),
    .status_o   (status)
  );

  clk_sw_div #(.MAX_SHIFT(MAX_SHIFT), .DIV_RST(DIV_RST)) u_div (
    .main_clk_i(main_clk_i),
    .rst_ni    (rst_ni),
    .div_i     (ctrl.div),
    .gate_i    (main_gate),
    .div_clk_o (div_clk)
  );

  // a stopped oscillator can never be selected
  assign want_main = !ctrl.sel_sub && !ctrl.stop;

  clk_sw_branch #(.SYNC_STAGES(SYNC_STAGES), .RST_ON(1'b1)) u_main_br (
    .clk_i (div_clk),
    .rst_ni(rst_ni),
    .req_i (want_main && !sub_gate),
    .gate_o(main_gate)
  );

  clk_sw_branch #(.SYNC_STAGES(SYNC_STAGES), .RST_ON(1'b0)) u_sub_br (
    .clk_i (sub_clk_i),
    .rst_ni(rst_ni),
    .req_i (!want_main && !main_gate),
    .gate_o(sub_gate)
  );

  assign cpu_clk_o     = (div_clk & main_gate) | (sub_clk_i & sub_gate);
  assign main_osc_en_o = !ctrl.stop || main_gate;
  assign rdata_o       = {status, ctrl};

  p_one_gate_r5: assert property (@(posedge sub_clk_i) disable iff (!rst_ni)
    !(main_gate && sub_gate));
endmodule

// File: tb/cpu_clk_switch_tb.sv
module cpu_clk_switch_tb;
  localparam real T_MAIN = 20.0;
  localparam real T_SUB  = 660.0;
  localparam logic [4:0] M_STOP = 5'b00001;
  localparam logic [4:0] M_SEL  = 5'b00010;
  localparam logic [4:0] M_DIV  = 5'b11100;

  logic       main_clk = 1'b0;
  logic       sub_clk  = 1'b0;
  logic       rst_ni;
  logic       wr = 1'b0;
  logic [4:0] wmask = '0;
  logic [4:0] wdata = '0;
  logic [5:0] rdata;
  logic       osc_en;
  logic       cpu_clk;

  int  n_chk = 0, n_fail = 0;
  real last_edge = 0.0, min_w = 1.0e9;
  bit  mon_on = 1'b0;

  cpu_clk_switch u_dut (
    .main_clk_i   (main_clk),
    .sub_clk_i    (sub_clk),
    .rst_ni       (rst_ni),
    .wr_i         (wr),
    .wmask_i      (wmask),
    .wdata_i      (wdata),
    .rdata_o      (rdata),
    .main_osc_en_o(osc_en),
    .cpu_clk_o    (cpu_clk)
  );

  always #(T_MAIN/2) if (osc_en === 1'b1) main_clk = ~main_clk;
  always #(T_SUB/2) sub_clk = ~sub_clk;

  always @(cpu_clk) begin
    if (mon_on && ($realtime - last_edge) < min_w) min_w = $realtime - last_edge;
    last_edge = $realtime;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.1f expected %0.1f", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] m, input logic [4:0] d);
    @(negedge sub_clk);
    wr = 1'b1; wmask = m; wdata = d;
    @(negedge sub_clk);
    wr = 1'b0; wmask = '0;
  endtask

  task automatic wait_sub(input int n);
    repeat (n) @(negedge sub_clk);
  endtask

  task automatic meas(output real p);
    real t0;
    repeat (3) @(posedge cpu_clk);
    t0 = $realtime;
    @(posedge cpu_clk);
    p = $realtime - t0;
  endtask

  task automatic chk_period(input string req, input real exp);
    real p;
    meas(p);
    chk((p > exp - 1.0) && (p < exp + 1.0), req, "cpu clock period", p, exp);
  endtask

  task automatic t_reset;
    chk(rdata == 6'h10, "R7", "reset readback", real'(rdata), real'(6'h10));
    chk(osc_en == 1'b1, "R1", "osc enable at reset", real'(osc_en), 1.0);
    chk_period("R7", 16.0 * T_MAIN);
  endtask

  task automatic t_to_sub;
    wr_reg(M_SEL, 5'b00010);
    chk(rdata[5] == 1'b0, "R6", "status right after write", real'(rdata[5]), 0.0);
    wait_sub(9);
    chk(rdata[5] == 1'b1, "R6", "status after handover", real'(rdata[5]), 1.0);
    chk(rdata[4:2] == 3'd4, "R4", "divider kept on select write", real'(rdata[4:2]), 4.0);
    chk_period("R6", T_SUB);
  endtask

  task automatic t_masked;
    wr_reg(M_DIV, 5'b01000);
    chk(rdata[4:0] == 5'b01010, "R2", "field layout after div write", real'(rdata[4:0]), 10.0);
    wr_reg(5'b00000, 5'b11111);
    chk(rdata[4:0] == 5'b01010, "R4", "empty mask write", real'(rdata[4:0]), 10.0);
  endtask

  task automatic t_stop_ignore;
    wr_reg(M_STOP, 5'b00001);
    wait_sub(1);
    chk(osc_en == 1'b0, "R1", "osc enable after stop", real'(osc_en), 0.0);
    wr_reg(M_SEL, 5'b00000);
    wait_sub(9);
    chk(rdata[5] == 1'b1, "R8", "status while main ignored", real'(rdata[5]), 1.0);
    chk_period("R8", T_SUB);
    wr_reg(M_STOP, 5'b00000);
    chk(osc_en == 1'b1, "R1", "osc enable after restart", real'(osc_en), 1.0);
    wait_sub(9);
    chk(rdata[5] == 1'b0, "R6", "status after restart", real'(rdata[5]), 0.0);
    chk_period("R3", 4.0 * T_MAIN);
    wr_reg(M_SEL, 5'b00010);
    wait_sub(9);
  endtask

  task automatic t_divs;
    min_w = 1.0e9;
    mon_on = 1'b1;
    for (int c = 0; c < 8; c++) begin
      real exp_p;
      exp_p = T_MAIN * real'(1 << ((c > 4) ? 4 : c));
      wr_reg(M_DIV, 5'(c << 2));
      wr_reg(M_SEL, 5'b00000);
      wait_sub(9);
      chk(rdata[5] == 1'b0, "R6", "status on main", real'(rdata[5]), 0.0);
      chk_period("R3", exp_p);
      wr_reg(M_SEL, 5'b00010);
      wait_sub(9);
      chk(rdata[5] == 1'b1, "R6", "status back on sub", real'(rdata[5]), 1.0);
    end
    mon_on = 1'b0;
    chk(min_w >= T_MAIN / 2.0 - 0.1, "R5", "shortest clock phase", min_w, T_MAIN / 2.0);
  endtask

  task automatic t_stop_main;
    wr_reg(M_DIV, 5'b00000);
    wr_reg(M_SEL, 5'b00000);
    wait_sub(9);
    chk(rdata[5] == 1'b0, "R9", "on main before stop", real'(rdata[5]), 0.0);
    mon_on = 1'b1;
    min_w = 1.0e9;
    wr_reg(M_STOP, 5'b00001);
    wait_sub(9);
    mon_on = 1'b0;
    chk(rdata[5] == 1'b1, "R9", "status after forced handover", real'(rdata[5]), 1.0);
    chk(osc_en == 1'b0, "R9", "osc enable after forced handover", real'(osc_en), 0.0);
    chk(min_w >= T_MAIN / 2.0 - 0.1, "R5", "shortest phase on forced handover", min_w, T_MAIN / 2.0);
    chk_period("R9", T_SUB);
  endtask

  initial begin
    #(200000 * T_MAIN);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    #(3 * T_SUB);
    rst_ni = 1'b1;
    wait_sub(1);
    t_reset();
    t_to_sub();
    t_masked();
    t_stop_ignore();
    t_divs();
    t_stop_main();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule